// File: doc/BRIEF.md
# Flash Bulk Transfer FIFO Engine

This block sits between a host register port and a flash-side word interface and moves flash contents in bulk through one FIFO window. To read, the host loads a start address, then writes the control register with the read-mode bit and a word count. The engine raises busy and fetches that many 32-bit words from consecutive flash word addresses into its FIFO. When the last word lands it drops busy. The host then empties the FIFO by reading one fixed register address over and over. A word count covers a trailing partial word, because the host rounds up before it programs the count.

To write, the host pushes words into the same FIFO address. A free-space field in the control register tells it how many words still fit. Outside read mode the engine streams queued words to the flash side through a valid/ready handshake. A separate mux register carries a host request bit. The engine answers it with an ownership grant, so the host can take the flash and give it back.

Registers are selected by a 2-bit word index: 0 control, 1 address, 2 FIFO window, 3 mux. Host reads are combinational. A FIFO pop, and every register update, takes effect at the clock edge where the strobe is sampled.

Top module: `flash_fifo_bridge`

## Requirements
- R1: After reset the control register reads with mode (bit 0), busy (bit 1) and overflow (bit 2) all clear. Its free-space field (bits 23:16) reads DEPTH, the mux register reads 0, `hostOwnsFlash` is 0 and no flash read is requested.
- R2: A control write with bit 0 set and a nonzero count in bits 15:8, made while idle, sets busy at that edge. A control write with a zero count starts nothing, and busy stays clear.
- R3: A read fetches words from the flash address held in the address register and the addresses after it, modulo 2^ADDR_W, one request at a time. Busy clears after the last word has been stored.
- R4: A count larger than DEPTH is clamped to DEPTH words.
- R5: Each host read of the FIFO address returns the oldest word and pops it. Words come back in fetch order. A read of an empty FIFO returns 0.
- R6: A control write with bit 0 clear ends read mode, and bit 0 then reads 0. Control writes made while busy are ignored, so the mode bit and the fetch stay unchanged.
- R7: Outside a fetch, each host write to the FIFO address pushes one word, and the free-space field drops by one. A push to a full FIFO is dropped and sets the overflow bit, which stays set until reset.
- R8: Outside read mode, queued words leave on `flashWrData` in push order, one per cycle in which `flashWrValid` and `flashWrReady` are both high.
- R9: Bit 0 of the mux register is the host request. The grant (`hostOwnsFlash`, mux bits 9:8 = 01) rises one cycle after the request is seen, and only while the engine is idle with nothing to drain. It falls one cycle after the request clears.
- R10: Starting a read discards any words still in the FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hostWrEn | input | 1 | Host register write strobe |
| hostRdEn | input | 1 | Host register read strobe (pops on FIFO address) |
| hostAddr | input | 2 | Register index |
| hostWrData | input | DATA_W | Host write data |
| hostRdData | output | DATA_W | Host read data, combinational |
| flashRdReq | output | 1 | One-cycle flash word read request |
| flashRdAddr | output | ADDR_W | Flash word address of the request |
| flashRdValid | input | 1 | Flash read data valid |
| flashRdData | input | DATA_W | Flash read data |
| flashWrValid | output | 1 | Queued write word available |
| flashWrData | output | DATA_W | Queued write word |
| flashWrReady | input | 1 | Flash side accepts the write word |
| hostOwnsFlash | output | 1 | Mux grant to the host |

## Verification
The bench goes after the count edges. A zero count must not start a fetch, and a design that started one would show busy. Counts above the depth must stop at DEPTH words, and a design that did not clamp would overrun the FIFO and hand back wrong or extra data. An address near the top of the range must wrap. Popping one word past the end must return zero, not a stale word. A design that did not flush at read start would return leftover write words ahead of the flash data. A design that counted or dropped at the full boundary incorrectly would show a wrong free-space field or a missing overflow bit. The mux is checked both idle and during a fetch: a design that granted too early, or released late, would show the grant in the wrong cycle.

// File: rtl/fbf_pkg.sv
package fbf_pkg;
  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_ADDR = 2'd1,
    REG_FIFO = 2'd2,
    REG_MUX  = 2'd3
  } regSel_e;

  typedef enum logic [1:0] {
    FS_IDLE  = 2'd0,
    FS_ISSUE = 2'd1,
    FS_WAIT  = 2'd2
  } fetchState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic push;
    logic pushFromFlash;
    logic pop;
    logic flush;
  } fifoStrobe_t;

  localparam int MODE_BIT  = 0;
  localparam int BUSY_BIT  = 1;
  localparam int OVF_BIT   = 2;
  localparam int CNT_LSB   = 8;
  localparam int CNT_W     = 8;
  localparam int SPACE_LSB = 16;
  localparam int OWNER_LSB = 8;
endpackage

// File: rtl/fbf_datapath.sv
module fbf_datapath
  import fbf_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int DATA_W = 32,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  fifoStrobe_t       stb,
  input  logic [DATA_W-1:0] hostData,
  input  logic [DATA_W-1:0] flashData,
  output logic [DATA_W-1:0] headWord,
  output logic              empty,
  output logic              full,
  output logic [CW-1:0]     fill
);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
  localparam logic [CW-1:0]    DEPTH_C  = CW'(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [DATA_W-1:0] pushData;

  assign pushData = stb.pushFromFlash ? flashData : hostData;
  assign empty    = (fill == '0);
  assign full     = (fill == DEPTH_C);
  assign headWord = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (stb.push && !stb.flush) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (rst || stb.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      fill  <= '0;
    end else begin
      if (stb.push) wrPtr <= (wrPtr == LAST_PTR) ? '0 : wrPtr + PTR_W'(1);
      if (stb.pop)  rdPtr <= (rdPtr == LAST_PTR) ? '0 : rdPtr + PTR_W'(1);
      case ({stb.push, stb.pop})
        2'b10:   fill <= fill + CW'(1);
        2'b01:   fill <= fill - CW'(1);
        default: fill <= fill;
      endcase
    end
  end

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
    stb.push |-> !full);
  assert_fill_bound_R7: assert property (@(posedge clk) disable iff (rst)
    fill <= DEPTH_C);
  assert_no_empty_pop_R5: assert property (@(posedge clk) disable iff (rst)
    stb.pop |-> !empty);
endmodule

// File: rtl/fbf_ctrl.sv
module fbf_ctrl
  import fbf_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hostWrEn,
  input  logic              hostRdEn,
  input  logic [1:0]        hostAddr,
  input  logic [DATA_W-1:0] hostWrData,
  output logic [DATA_W-1:0] hostRdData,
  output logic              flashRdReq,
  output logic [ADDR_W-1:0] flashRdAddr,
  input  logic              flashRdValid,
  output logic              flashWrValid,
  input  logic              flashWrReady,
  output logic              hostOwnsFlash,
  input  logic [DATA_W-1:0] headWord,
  input  logic              empty,
  input  logic              full,
  input  logic [CW-1:0]     fill,
  output fifoStrobe_t       stb
);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

  fetchState_e       state;
  logic              readMode, overflow, reqQ, grantQ;
  logic [ADDR_W-1:0] addrReg, fetchAddr;
  logic [CW-1:0]     remaining, clampCnt, spaceWords;
  logic [CNT_W-1:0]  cntField;
  logic ctrlWr, addrWr, muxWr, fifoWr, fifoRd;
  logic startRead, hostPush, hostDrop, flashPush, linkIdle, isIdle;

  assign isIdle    = (state == FS_IDLE);
  assign ctrlWr    = hostWrEn && (hostAddr == REG_CTRL);
  assign addrWr    = hostWrEn && (hostAddr == REG_ADDR);
  assign muxWr     = hostWrEn && (hostAddr == REG_MUX);
  assign fifoWr    = hostWrEn && (hostAddr == REG_FIFO) && isIdle;
  assign fifoRd    = hostRdEn && (hostAddr == REG_FIFO);
  assign cntField  = hostWrData[CNT_LSB +: CNT_W];
  assign clampCnt  = (32'(cntField) > DEPTH) ? DEPTH_C : CW'(cntField);
  assign startRead = ctrlWr && isIdle && hostWrData[MODE_BIT] && (cntField != '0);
  assign hostPush  = fifoWr && !full;
  assign hostDrop  = fifoWr && full;
  assign flashPush = (state == FS_WAIT) && flashRdValid;
  assign spaceWords = DEPTH_C - fill;

  assign flashRdReq   = (state == FS_ISSUE);
  assign flashRdAddr  = fetchAddr;
  assign flashWrValid = !empty && !readMode && isIdle;
  assign linkIdle     = isIdle && !flashWrValid;
  assign hostOwnsFlash = grantQ;

  always_comb begin
    stb               = '0;
    stb.flush         = startRead;
    stb.push          = flashPush || hostPush;
    stb.pushFromFlash = (state == FS_WAIT);
    stb.pop           = (fifoRd && !empty) || (flashWrValid && flashWrReady);
  end

  always_comb begin
    hostRdData = '0;
    case (hostAddr)
      REG_CTRL: begin
        hostRdData[MODE_BIT] = readMode;
        hostRdData[BUSY_BIT] = !isIdle;
        hostRdData[OVF_BIT]  = overflow;
        hostRdData[SPACE_LSB +: CW] = spaceWords;
      end
      REG_ADDR: hostRdData[ADDR_W-1:0] = addrReg;
      REG_FIFO: hostRdData = empty ? '0 : headWord;
      default: begin
        hostRdData[0] = reqQ;
        hostRdData[OWNER_LSB +: 2] = grantQ ? 2'b01 : 2'b00;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= FS_IDLE;
      readMode  <= 1'b0;
      overflow  <= 1'b0;
      reqQ      <= 1'b0;
      grantQ    <= 1'b0;
      addrReg   <= '0;
      fetchAddr <= '0;
      remaining <= '0;
    end else begin
      if (addrWr) addrReg <= hostWrData[ADDR_W-1:0];
      if (ctrlWr && isIdle) readMode <= hostWrData[MODE_BIT];
      if (hostDrop) overflow <= 1'b1;
      if (muxWr) reqQ <= hostWrData[0];
      grantQ <= reqQ && (grantQ || linkIdle);
      case (state)
        FS_IDLE: if (startRead) begin
          state     <= FS_ISSUE;
          fetchAddr <= addrReg;
          remaining <= clampCnt;
        end
        FS_ISSUE: state <= FS_WAIT;
        default: if (flashRdValid) begin
          remaining <= remaining - CW'(1);
          fetchAddr <= fetchAddr + ADDR_W'(1);
          state     <= (remaining == CW'(1)) ? FS_IDLE : FS_ISSUE;
        end
      endcase
    end
  end

  assert_single_req_R3: assert property (@(posedge clk) disable iff (rst)
    flashRdReq |=> !flashRdReq);
  assert_clamp_R4: assert property (@(posedge clk) disable iff (rst)
    !isIdle |-> (remaining != '0 && remaining <= DEPTH_C));
  assert_busy_ignore_R6: assert property (@(posedge clk) disable iff (rst)
    (!isIdle && ctrlWr) |=> $stable(readMode));
  assert_grant_idle_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(grantQ) |-> $past(linkIdle));
  assert_release_R9: assert property (@(posedge clk) disable iff (rst)
    !reqQ |=> !grantQ);
endmodule

// File: rtl/flash_fifo_bridge.sv
module flash_fifo_bridge
  import fbf_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hostWrEn,
  input  logic              hostRdEn,
  input  logic [1:0]        hostAddr,
  input  logic [DATA_W-1:0] hostWrData,
  output logic [DATA_W-1:0] hostRdData,
  output logic              flashRdReq,
  output logic [ADDR_W-1:0] flashRdAddr,
  input  logic              flashRdValid,
  input  logic [DATA_W-1:0] flashRdData,
  output logic              flashWrValid,
  output logic [DATA_W-1:0] flashWrData,
  input  logic              flashWrReady,
  output logic              hostOwnsFlash
);
  localparam int CW = $clog2(DEPTH + 1);

  fifoStrobe_t       stb;
  logic [DATA_W-1:0] headWord;
  logic              empty, full;
  logic [CW-1:0]     fill;

  assign flashWrData = headWord;

  fbf_ctrl #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst(rst),
    .hostWrEn(hostWrEn), .hostRdEn(hostRdEn), .hostAddr(hostAddr),
    .hostWrData(hostWrData), .hostRdData(hostRdData),
    .flashRdReq(flashRdReq), .flashRdAddr(flashRdAddr), .flashRdValid(flashRdValid),
    .flashWrValid(flashWrValid), .flashWrReady(flashWrReady),
    .hostOwnsFlash(hostOwnsFlash),
    .headWord(headWord), .empty(empty), .full(full), .fill(fill), .stb(stb)
  );

  fbf_datapath #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_datapath (
    .clk(clk), .rst(rst), .stb(stb),
    .hostData(hostWrData), .flashData(flashRdData),
    .headWord(headWord), .empty(empty), .full(full), .fill(fill)
  );
endmodule

// File: tb/flash_fifo_bridge_bench.sv
module flash_fifo_bridge_bench;
  localparam int DEPTH  = 32;
  localparam int ADDR_W = 24;
  localparam int DATA_W = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hostWrEn = 1'b0, hostRdEn = 1'b0;
  logic [1:0] hostAddr = 2'd0;
  logic [DATA_W-1:0] hostWrData = '0;
  logic [DATA_W-1:0] hostRdData;
  logic flashRdReq;
  logic [ADDR_W-1:0] flashRdAddr;
  logic flashRdValid = 1'b0;
  logic [DATA_W-1:0] flashRdData = '0;
  logic flashWrValid;
  logic [DATA_W-1:0] flashWrData;
  logic flashWrReady = 1'b0;
  logic hostOwnsFlash;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  flash_fifo_bridge #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_flash_fifo_bridge (
    .clk(clk), .rst(rst), .hostWrEn(hostWrEn), .hostRdEn(hostRdEn), .hostAddr(hostAddr),
    .hostWrData(hostWrData), .hostRdData(hostRdData),
    .flashRdReq(flashRdReq), .flashRdAddr(flashRdAddr),
    .flashRdValid(flashRdValid), .flashRdData(flashRdData),
    .flashWrValid(flashWrValid), .flashWrData(flashWrData), .flashWrReady(flashWrReady),
    .hostOwnsFlash(hostOwnsFlash)
  );

  function automatic logic [31:0] memWord(input logic [ADDR_W-1:0] a);
    return (32'(a) * 32'h9E37_79B1) ^ 32'h5A5A_0000;
  endfunction

  function automatic int clampCount(input int c);
    return (c > DEPTH) ? DEPTH : c;
  endfunction

  // flash read model with random latency
  logic pend = 1'b0;
  int   lat = 0;
  logic [ADDR_W-1:0] pendAddr = '0;
  always @(posedge clk) begin
    flashRdValid <= 1'b0;
    if (flashRdReq) begin
      pend <= 1'b1;
      lat <= $urandom_range(0, 3);
      pendAddr <= flashRdAddr;
    end else if (pend) begin
      if (lat == 0) begin
        flashRdValid <= 1'b1;
        flashRdData <= memWord(pendAddr);
        pend <= 1'b0;
      end else lat <= lat - 1;
    end
  end

  // write drain capture
  logic [31:0] drained [256];
  int drainCnt = 0;
  always @(posedge clk) begin
    if (flashWrValid && flashWrReady) begin
      drained[drainCnt] <= flashWrData;
      drainCnt <= drainCnt + 1;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic hostWrite(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    hostAddr = a; hostWrData = d; hostWrEn = 1'b1;
    @(posedge clk); #1;
    hostWrEn = 1'b0;
  endtask

  task automatic hostRead(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    hostAddr = a; hostRdEn = 1'b1;
    #1 d = hostRdData;
    @(posedge clk); #1;
    hostRdEn = 1'b0;
  endtask

  task automatic waitIdle(input string req);
    logic [31:0] v;
    int n = 0;
    hostRead(2'd0, v);
    while (v[1] && n < 3000) begin
      hostRead(2'd0, v);
      n++;
    end
    check(!v[1], req, v, v & ~32'h2);
  endtask

  task automatic readBlock(input logic [ADDR_W-1:0] a, input int cnt);
    logic [31:0] v;
    int n;
    n = clampCount(cnt);
    hostWrite(2'd1, 32'(a));
    hostWrite(2'd0, (32'(cnt) << 8) | 32'h1);
    hostRead(2'd0, v);
    check(v[1] == 1'b1, "R2 busy after start", v, 32'h2);
    waitIdle("R3 busy clears");
    for (int i = 0; i < n; i++) begin
      hostRead(2'd2, v);
      check(v == memWord(a + ADDR_W'(i)), (cnt > DEPTH) ? "R4 clamped data" : "R3 fetched data", v, memWord(a + ADDR_W'(i)));
    end
    hostRead(2'd2, v);
    check(v == 32'h0, "R5 empty pop after block (R4 count)", v, 32'h0);
    hostWrite(2'd0, 32'h0);
    hostRead(2'd0, v);
    check(v[0] == 1'b0, "R6 zero write ends read mode", v, v & ~32'h1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'h0, 32'h1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] pushed [DEPTH + 2];
    int seedDummy;
    seedDummy = $urandom(32'h0000_5EED);
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;

    // R1 reset state
    hostRead(2'd0, v);
    check(v == (32'(DEPTH) << 16), "R1 ctrl reset", v, 32'(DEPTH) << 16);
    hostRead(2'd3, v);
    check(v == 32'h0, "R1 mux reset", v, 32'h0);
    check(hostOwnsFlash == 1'b0 && flashRdReq == 1'b0, "R1 outputs idle", {30'h0, hostOwnsFlash, flashRdReq}, 32'h0);

    // R2 zero count starts nothing
    hostWrite(2'd0, 32'h1);
    hostRead(2'd0, v);
    check(v[1] == 1'b0, "R2 zero count no busy", v, 32'h1 | (32'(DEPTH) << 16));
    check(v[0] == 1'b1, "R2 mode bit set by zero count write", v, 32'h1 | (32'(DEPTH) << 16));
    hostWrite(2'd0, 32'h0);

    // directed reads
    readBlock(24'h000010, 1);
    readBlock(24'hFFFFFE, 3);
    readBlock(24'h001000, DEPTH);
    readBlock(24'h002000, DEPTH + 8);
    readBlock(24'h003000, 255);

    // random reads
    for (int k = 0; k < 8; k++) begin
      readBlock(ADDR_W'($urandom()), int'($urandom_range(1, 48)));
    end

    // R6 control write while busy is ignored
    hostWrite(2'd1, 32'h000500);
    hostWrite(2'd0, (32'd20 << 8) | 32'h1);
    hostWrite(2'd0, 32'h0);
    waitIdle("R6 busy clears");
    hostRead(2'd0, v);
    check(v[0] == 1'b1, "R6 mode kept after write during busy", v, v | 32'h1);
    for (int i = 0; i < 20; i++) begin
      hostRead(2'd2, v);
      check(v == memWord(24'h000500 + ADDR_W'(i)), "R6 fetch unchanged", v, memWord(24'h000500 + ADDR_W'(i)));
    end
    hostRead(2'd2, v);
    check(v == 32'h0, "R5 empty pop", v, 32'h0);
    hostWrite(2'd0, 32'h0);

    // R9 mux handshake while idle
    hostWrite(2'd3, 32'h1);
    check(hostOwnsFlash == 1'b0, "R9 grant not in request cycle", {31'h0, hostOwnsFlash}, 32'h0);
    @(posedge clk); #1;
    check(hostOwnsFlash == 1'b1, "R9 grant one cycle later", {31'h0, hostOwnsFlash}, 32'h1);
    hostRead(2'd3, v);
    check(v == 32'h101, "R9 mux status host", v, 32'h101);
    hostWrite(2'd3, 32'h0);
    @(posedge clk); #1;
    check(hostOwnsFlash == 1'b0, "R9 release one cycle later", {31'h0, hostOwnsFlash}, 32'h0);
    hostRead(2'd3, v);
    check(v == 32'h0, "R9 mux status released", v, 32'h0);

    // R9 request during fetch is held off
    hostWrite(2'd1, 32'h000700);
    hostWrite(2'd0, (32'(DEPTH) << 8) | 32'h1);
    hostWrite(2'd3, 32'h1);
    @(posedge clk); #1;
    check(hostOwnsFlash == 1'b0, "R9 no grant while busy", {31'h0, hostOwnsFlash}, 32'h0);
    waitIdle("R9 busy clears");
    @(posedge clk); #1;
    check(hostOwnsFlash == 1'b1, "R9 grant after fetch", {31'h0, hostOwnsFlash}, 32'h1);
    for (int i = 0; i < DEPTH; i++) hostRead(2'd2, v);
    hostWrite(2'd3, 32'h0);
    hostWrite(2'd0, 32'h0);

    // R7 push, space and overflow; R8 drain order
    flashWrReady = 1'b0;
    for (int i = 0; i < 5; i++) begin
      pushed[i] = $urandom();
      hostWrite(2'd2, pushed[i]);
    end
    hostRead(2'd0, v);
    check(v[23:16] == 8'(DEPTH - 5), "R7 space after five pushes", v, 32'(DEPTH - 5) << 16);
    for (int i = 5; i < DEPTH + 2; i++) begin
      pushed[i] = $urandom();
      hostWrite(2'd2, pushed[i]);
      if (i == DEPTH - 1) begin
        hostRead(2'd0, v);
        check(v[23:16] == 8'd0 && v[2] == 1'b0, "R7 full without overflow", v, 32'h0);
      end
    end
    hostRead(2'd0, v);
    check(v[2] == 1'b1 && v[23:16] == 8'd0, "R7 overflow on push to full", v, 32'h4);
    @(negedge clk);
    flashWrReady = 1'b1;
    repeat (DEPTH + 6) @(posedge clk);
    #1;
    check(drainCnt == DEPTH, "R8 drained word count (R7 drops)", 32'(drainCnt), 32'(DEPTH));
    for (int i = 0; i < DEPTH; i++) begin
      check(drained[i] == pushed[i], "R8 drain order", drained[i], pushed[i]);
    end
    hostRead(2'd0, v);
    check(v[23:16] == 8'(DEPTH) && v[2] == 1'b1, "R7 space restored, overflow sticky", v, (32'(DEPTH) << 16) | 32'h4);

    // R10 read start flushes stale write words
    @(negedge clk);
    flashWrReady = 1'b0;
    for (int i = 0; i < 3; i++) hostWrite(2'd2, 32'hDEAD_0000 + 32'(i));
    hostWrite(2'd1, 32'h000900);
    hostWrite(2'd0, (32'd2 << 8) | 32'h1);
    waitIdle("R10 busy clears");
    for (int i = 0; i < 2; i++) begin
      hostRead(2'd2, v);
      check(v == memWord(24'h000900 + ADDR_W'(i)), "R10 flash data after flush", v, memWord(24'h000900 + ADDR_W'(i)));
    end
    hostRead(2'd2, v);
    check(v == 32'h0, "R10 stale words gone", v, 32'h0);
    hostWrite(2'd0, 32'h0);
    check(drainCnt == DEPTH, "R8 nothing drained with ready low", 32'(drainCnt), 32'(DEPTH));

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule